// File: doc/BRIEF.md
# Interrupt Pending Controller with Time Base and Decrementer

This block holds one pending flag for each of eight interrupt sources that belong to a single hardware thread. Neighbouring logic raises or drops a single source by its index, or wipes every source in one cycle. The block also keeps two counters that move on a tick strobe. The first is a time base that only counts up. The second is a decrementer that counts down to zero and then marks its own source pending on each later tick.

The core presents an external-enable bit and two privilege bits, hypervisor state and problem state. From these and the pending flags, the block drives a take-interrupt signal. The hypervisor doorbell can get past the enable mask when the thread is not in hypervisor state, or when it runs in problem state.

When the core acknowledges, the block chooses among three sources only: decrementer, then privileged doorbell, then hypervisor doorbell. On the next cycle it returns the code of the chosen source and drops that source's flag. If none of the three is pending, it returns a no-fault code.

Top module: `intr_pend_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all pending flags are clear, the time base is 0, the decrementer holds all ones, and `ack_vld` and `idx_err` are low.
- R2: A post with an index 0..7 sets that source's bit in `pending` on the next cycle, and a clear drops it. If a post and a clear name the same index in the same cycle, the flag ends clear.
- R3: A post or clear whose 4-bit index is 8 or above changes no flag. It drives `idx_err` high for exactly the following cycle.
- R4: Clear-all leaves all eight flags clear on the next cycle. It overrides any post, underflow or acknowledge in the same cycle.
- R5: Each cycle with `tick` high adds one to `time_base`. The time base wraps from all ones to 0.
- R6: On a tick, a nonzero decrementer loses one. A tick that finds the decrementer at zero keeps it at zero and sets `pending[4]`.
- R7: `dec_reload` loads the decrementer with all ones on the next cycle. This wins over a tick decrement in the same cycle.
- R8: `take_irq` is high whenever `msr_ee` is high and any pending bit is set. This output is combinational on the current flags and inputs.
- R9: When `pending[7]` is set, `take_irq` is high if `msr_hv` is low or `msr_pr` is high, whatever the value of `msr_ee`.
- R10: An acknowledge gives `ack_vld` high for one cycle, on the next cycle. `ack_code` names the first pending source in the order 4, 6, 7 (decrementer, privileged doorbell, hypervisor doorbell), and that flag is cleared. `ack_code` holds its value between acknowledges.
- R11: An acknowledge that finds none of sources 4, 6 or 7 pending returns code 0, which means no fault. It leaves every flag unchanged.
- R12: An acknowledge and a post that select the same source in the same cycle leave that flag set. A decrementer underflow in the same cycle as an acknowledge of source 4 also leaves flag 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Advance time base and decrementer |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 4 | Source index to post |
| clr_vld | input | 1 | Single-source clear strobe |
| clr_idx | input | 4 | Source index to clear |
| clr_all | input | 1 | Clear every pending flag |
| dec_reload | input | 1 | Load decrementer with all ones |
| msr_ee | input | 1 | External-enable bit from the core |
| msr_hv | input | 1 | Hypervisor-state bit from the core |
| msr_pr | input | 1 | Problem-state bit from the core |
| ack | input | 1 | Interrupt acknowledge strobe |
| take_irq | output | 1 | Core should take an interrupt |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_code | output | 3 | Selected source code, 0 = no fault |
| idx_err | output | 1 | Out-of-range index seen last cycle |
| pending | output | 8 | Pending flags, bit i = source i |
| time_base | output | TB_W | Time-base counter |
| dec_value | output | DEC_W | Decrementer value |

## Verification
On every cycle, the assertions check these relations:
- the time base steps by one on each tick;
- the decrementer sticks at zero and then raises source 4;
- a reload produces all ones;
- clear-all empties the flags;
- a bad index produces an error pulse;
- the acknowledge valid pulse appears on time;
- the hypervisor doorbell gets past the mask.

Some behaviours appear only in the bench's scenarios:
- a post losing to a clear on the same index;
- a post surviving an acknowledge of the same source;
- walking the 4, 6, 7 acknowledge order down to the no-fault code;
- the time base wrapping and the decrementer reaching zero.

The bench uses narrow counters so that these long-count events happen within the run.

// File: rtl/intr_pend_pkg.sv
// Package: shared source numbering for the interrupt pending controller.
// Assumes eight sources; index 0 has the highest architectural priority.
package intr_pend_pkg;

    localparam int NUM_SRC = 8;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_SYS_RESET    = 3'd0,
        SRC_MCHK         = 3'd1,
        SRC_EXT_DIRECT   = 3'd2,
        SRC_EXT_MEDIATED = 3'd3,
        SRC_DECR         = 3'd4,
        SRC_PERF         = 3'd5,
        SRC_DB_PRIV      = 3'd6,
        SRC_DB_HYP       = 3'd7
    } src_e;

    // Acknowledge result when none of the selectable sources is pending.
    localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;

endpackage

// File: rtl/tick_timers.sv
// Module: tick_timers
// Holds the up-counting time base and the down-counting decrementer.
// Both move only on tick. The decrementer stops at zero and reports an
// underflow event on every tick that finds it at zero.
// Assumes dec_reload and tick are single-cycle qualified strobes.
module tick_timers #(
    parameter int TB_W  = 64,
    parameter int DEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dec_reload,
    output logic [TB_W-1:0]  tb_q,
    output logic [DEC_W-1:0] dec_q,
    output logic             dec_underflow
);

    localparam logic [TB_W-1:0]  TB_ONE  = TB_W'(1);
    localparam logic [DEC_W-1:0] DEC_ONE = DEC_W'(1);

    logic dec_is_zero;
    assign dec_is_zero   = (dec_q == '0);
    assign dec_underflow = tick && dec_is_zero;

    // Purpose: time base advances by one per tick and wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tb_q <= '0;
        else if (tick)
            tb_q <= tb_q + TB_ONE;
    end

    // Purpose: decrementer reloads to all ones or counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dec_q <= '1;
        else if (dec_reload)
            dec_q <= '1;
        else if (tick && !dec_is_zero)
            dec_q <= dec_q - DEC_ONE;
    end

    p_tb_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tb_q == $past(tb_q) + TB_ONE));

    p_tb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tb_q));

    p_dec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dec_is_zero && !dec_reload) |=> (dec_q == '0));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_reload |=> (&dec_q));

endmodule

// File: rtl/pend_flags.sv
// Module: pend_flags
// One pending flag per source, set by post or decrementer underflow and
// dropped by single clear, clear-all or acknowledge. Priority per flag,
// highest first: clear-all, single clear, set (post/underflow), ack clear.
// Out-of-range indices are ignored and flagged one cycle later.
module pend_flags
    import intr_pend_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_vld,
    input  logic [IDX_W-1:0]   post_idx,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               clr_all,
    input  logic               set_dec,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               idx_err_q
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_SRC);

    logic post_bad;
    logic clr_bad;
    assign post_bad = post_vld && (post_idx >= IDX_LIMIT);
    assign clr_bad  = clr_vld  && (clr_idx  >= IDX_LIMIT);

    // Purpose: one-cycle error pulse for any rejected index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_err_q <= 1'b0;
        else
            idx_err_q <= post_bad || clr_bad;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        localparam bit IS_DEC = (i == int'(SRC_DECR));
        logic hit_post;
        logic hit_clr;
        logic hit_set;
        assign hit_post = post_vld && (post_idx == IDX_W'(i));
        assign hit_clr  = clr_vld  && (clr_idx  == IDX_W'(i));
        assign hit_set  = hit_post || (IS_DEC && set_dec);

        // Purpose: update one pending flag by the fixed priority order.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (clr_all || hit_clr)
                pend_q[i] <= 1'b0;
            else if (hit_set)
                pend_q[i] <= 1'b1;
            else if (ack_clr[i])
                pend_q[i] <= 1'b0;
        end

        p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hit_clr |=> !pend_q[i]);

        p_set_beats_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_set && !hit_clr && !clr_all) |=> pend_q[i]);
    end

    p_clr_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_q == '0));

    p_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_bad || clr_bad) |=> idx_err_q);

    p_bad_post_noeffect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_bad && !clr_vld && !clr_all && !set_dec && (ack_clr == '0))
        |=> $stable(pend_q));

endmodule

// File: rtl/ack_sel.sv
// Module: ack_sel
// On acknowledge, picks the first pending source among decrementer,
// privileged doorbell and hypervisor doorbell, requests its clear in the
// same cycle and registers the code with a valid pulse for the next cycle.
// Assumes ack is a single-cycle strobe; the code holds between acks.
module ack_sel
    import intr_pend_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack,
    input  logic               pend_dec,
    input  logic               pend_db_priv,
    input  logic               pend_db_hyp,
    output logic [NUM_SRC-1:0] ack_clr,
    output logic               ack_vld_q,
    output logic [CODE_W-1:0]  ack_code_q
);

    logic [CODE_W-1:0]  pick_code;
    logic [NUM_SRC-1:0] pick_vec;

    // Purpose: fixed-order selection among the three selectable sources.
    always_comb begin
        pick_code = CODE_NONE;
        pick_vec  = '0;
        if (pend_dec) begin
            pick_code = SRC_DECR;
            pick_vec[SRC_DECR] = 1'b1;
        end else if (pend_db_priv) begin
            pick_code = SRC_DB_PRIV;
            pick_vec[SRC_DB_PRIV] = 1'b1;
        end else if (pend_db_hyp) begin
            pick_code = SRC_DB_HYP;
            pick_vec[SRC_DB_HYP] = 1'b1;
        end
    end

    assign ack_clr = ack ? pick_vec : '0;

    // Purpose: register the acknowledge result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld_q  <= 1'b0;
            ack_code_q <= CODE_NONE;
        end else begin
            ack_vld_q <= ack;
            if (ack)
                ack_code_q <= pick_code;
        end
    end

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_vld_q);

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_vld_q);

    p_ack_dec_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_dec) |=> (ack_code_q == SRC_DECR));

    p_ack_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend_dec && !pend_db_priv && !pend_db_hyp)
        |=> (ack_code_q == CODE_NONE));

endmodule

// File: rtl/take_eval.sv
// Module: take_eval
// Combinational take-interrupt decision: any pending source under the
// external enable, or the hypervisor doorbell when the thread is outside
// hypervisor state or in problem state, regardless of the enable.
module take_eval
    import intr_pend_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic               msr_ee,
    input  logic               msr_hv,
    input  logic               msr_pr,
    output logic               take
);

    logic any_masked;
    logic hyp_bypass;

    // Purpose: combine the masked and bypass paths.
    always_comb begin
        any_masked = msr_ee && (|pend);
        hyp_bypass = pend[SRC_DB_HYP] && (!msr_hv || msr_pr);
        take       = any_masked || hyp_bypass;
    end

endmodule

// File: rtl/intr_pend_ctrl.sv
// Module: intr_pend_ctrl (top)
// Pending-interrupt controller for one hardware thread: eight source
// flags, a tick-driven time base and decrementer, the take-interrupt
// decision and the acknowledge selector. Synchronous active-low reset.
module intr_pend_ctrl
    import intr_pend_pkg::*;
#(
    parameter int TB_W  = 64,
    parameter int DEC_W = 64,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               post_vld,
    input  logic [IDX_W-1:0]   post_idx,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               clr_all,
    input  logic               dec_reload,
    input  logic               msr_ee,
    input  logic               msr_hv,
    input  logic               msr_pr,
    input  logic               ack,
    output logic               take_irq,
    output logic               ack_vld,
    output logic [CODE_W-1:0]  ack_code,
    output logic               idx_err,
    output logic [NUM_SRC-1:0] pending,
    output logic [TB_W-1:0]    time_base,
    output logic [DEC_W-1:0]   dec_value
);

    logic               dec_underflow;
    logic [NUM_SRC-1:0] ack_clr;

    tick_timers #(
        .TB_W  (TB_W),
        .DEC_W (DEC_W)
    ) u_timers (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .dec_reload    (dec_reload),
        .tb_q          (time_base),
        .dec_q         (dec_value),
        .dec_underflow (dec_underflow)
    );

    pend_flags #(
        .IDX_W (IDX_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_vld  (post_vld),
        .post_idx  (post_idx),
        .clr_vld   (clr_vld),
        .clr_idx   (clr_idx),
        .clr_all   (clr_all),
        .set_dec   (dec_underflow),
        .ack_clr   (ack_clr),
        .pend_q    (pending),
        .idx_err_q (idx_err)
    );

    ack_sel u_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack          (ack),
        .pend_dec     (pending[SRC_DECR]),
        .pend_db_priv (pending[SRC_DB_PRIV]),
        .pend_db_hyp  (pending[SRC_DB_HYP]),
        .ack_clr      (ack_clr),
        .ack_vld_q    (ack_vld),
        .ack_code_q   (ack_code)
    );

    take_eval u_take (
        .pend   (pending),
        .msr_ee (msr_ee),
        .msr_hv (msr_hv),
        .msr_pr (msr_pr),
        .take   (take_irq)
    );

    p_hyp_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[SRC_DB_HYP] && (!msr_hv || msr_pr)) |-> take_irq);

    p_masked_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_ee && (pending != '0)) |-> take_irq);

    p_underflow_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (dec_value == '0) && !clr_all &&
         !(clr_vld && clr_idx == IDX_W'(SRC_DECR))) |=> pending[SRC_DECR]);

    p_no_take_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !take_irq);

endmodule

// File: tb/intr_pend_ctrl_bench.sv
`timescale 1ns/100ps
module intr_pend_ctrl_bench;

    localparam int TB_W  = 8;
    localparam int DEC_W = 8;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, post_vld = 0, clr_vld = 0, clr_all = 0, dec_reload = 0;
    logic [IDX_W-1:0] post_idx = '0, clr_idx = '0;
    logic msr_ee = 0, msr_hv = 1, msr_pr = 0, ack = 0;
    logic take_irq, ack_vld, idx_err;
    logic [2:0] ack_code;
    logic [7:0] pending;
    logic [TB_W-1:0] time_base;
    logic [DEC_W-1:0] dec_value;

    always #2.5 clk = ~clk;

    intr_pend_ctrl #(.TB_W(TB_W), .DEC_W(DEC_W), .IDX_W(IDX_W)) u_intr_pend_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .post_vld(post_vld),
        .post_idx(post_idx), .clr_vld(clr_vld), .clr_idx(clr_idx),
        .clr_all(clr_all), .dec_reload(dec_reload), .msr_ee(msr_ee),
        .msr_hv(msr_hv), .msr_pr(msr_pr), .ack(ack), .take_irq(take_irq),
        .ack_vld(ack_vld), .ack_code(ack_code), .idx_err(idx_err),
        .pending(pending), .time_base(time_base), .dec_value(dec_value)
    );

    // Behavioural reference state
    bit [7:0]       m_pend;
    int unsigned    m_tb, m_dec;
    bit             m_err, m_ackv, m_started;
    int unsigned    m_code;
    string          cur_req = "R1";
    int             n_checks = 0, n_fails = 0;
    bit             done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_tb = 0; m_dec = 255; m_err = 0; m_ackv = 0; m_code = 0;
        end else begin
            bit [7:0] np;
            int sel;
            np = m_pend;
            sel = -1;
            if (m_pend[4]) sel = 4;
            else if (m_pend[6]) sel = 6;
            else if (m_pend[7]) sel = 7;
            if (ack) begin
                if (sel >= 0) np[sel] = 1'b0;
                m_code = (sel >= 0) ? sel : 0;
            end
            m_ackv = ack;
            if (tick && m_dec == 0) np[4] = 1'b1;
            if (post_vld && post_idx < 8) np[post_idx] = 1'b1;
            if (clr_vld && clr_idx < 8) np[clr_idx] = 1'b0;
            if (clr_all) np = '0;
            m_err = (post_vld && post_idx >= 8) || (clr_vld && clr_idx >= 8);
            if (dec_reload) m_dec = 255;
            else if (tick && m_dec != 0) m_dec = m_dec - 1;
            if (tick) m_tb = (m_tb + 1) % 256;
            m_pend = np;
        end
        m_started = 1;
    end

    task automatic chk(input string what, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (m_started && !done) begin
            bit exp_take;
            exp_take = (msr_ee && m_pend != 0) || (m_pend[7] && (!msr_hv || msr_pr));
            chk("pending",   pending,   m_pend);
            chk("time_base", time_base, m_tb);
            chk("dec_value", dec_value, m_dec);
            chk("idx_err",   idx_err,   m_err);
            chk("ack_vld",   ack_vld,   m_ackv);
            chk("ack_code",  ack_code,  m_code);
            chk("take_irq",  take_irq,  exp_take);
        end
    end

    task automatic idle_inputs();
        tick = 0; post_vld = 0; clr_vld = 0; clr_all = 0; dec_reload = 0; ack = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
        idle_inputs();
    endtask

    task automatic post(input int idx);
        @(negedge clk); #1; idle_inputs();
        post_vld = 1; post_idx = IDX_W'(idx);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        step(); step();
        // R2: post, clear, post+clear same index
        cur_req = "R2";
        post(2); post(5); step();
        @(negedge clk); #1; idle_inputs(); clr_vld = 1; clr_idx = 2;
        @(negedge clk); #1; idle_inputs(); post_vld = 1; post_idx = 3; clr_vld = 1; clr_idx = 3;
        step(); step();
        // R3: out-of-range indices
        cur_req = "R3";
        post(9); step();
        @(negedge clk); #1; idle_inputs(); clr_vld = 1; clr_idx = 12;
        step(); step();
        // R8: enable with a masked source pending
        cur_req = "R8";
        @(negedge clk); #1; idle_inputs(); msr_ee = 1;
        step(); step();
        // R4: clear-all beats a same-cycle post
        cur_req = "R4";
        @(negedge clk); #1; idle_inputs(); clr_all = 1; post_vld = 1; post_idx = 1;
        step(); step();
        // R9: hypervisor doorbell bypass
        cur_req = "R9";
        @(negedge clk); #1; idle_inputs(); msr_ee = 0; msr_hv = 1; msr_pr = 0;
        post(7); step(); step();
        @(negedge clk); #1; msr_hv = 0; step(); step();
        @(negedge clk); #1; msr_hv = 1; msr_pr = 1; step(); step();
        @(negedge clk); #1; msr_pr = 0; step();
        // R10: acknowledge order 6 then 7
        cur_req = "R10";
        post(6); post(2); step();
        @(negedge clk); #1; idle_inputs(); ack = 1;
        step();
        @(negedge clk); #1; idle_inputs(); ack = 1;
        step(); step();
        // R11: ack with only non-selectable source pending
        cur_req = "R11";
        @(negedge clk); #1; idle_inputs(); ack = 1;
        step(); step();
        // R12: ack and post on the same source
        cur_req = "R12";
        post(6); step();
        @(negedge clk); #1; idle_inputs(); ack = 1; post_vld = 1; post_idx = 6;
        step(); step();
        @(negedge clk); #1; idle_inputs(); clr_all = 1; step();
        // R5/R6: run ticks past decrementer zero and time base wrap
        cur_req = "R6";
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); #1; idle_inputs(); tick = 1;
            if (k > 258) cur_req = "R5";
        end
        step();
        // R12: underflow tick with ack of source 4 keeps flag 4
        cur_req = "R12";
        @(negedge clk); #1; idle_inputs(); tick = 1; ack = 1;
        step(); step();
        // R10: ack selects decrementer first
        cur_req = "R10";
        post(7); step();
        @(negedge clk); #1; idle_inputs(); ack = 1;
        step(); step();
        // R7: reload wins over tick
        cur_req = "R7";
        @(negedge clk); #1; idle_inputs(); dec_reload = 1; tick = 1;
        step();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1; idle_inputs(); tick = 1;
        end
        step(); step();
        // R1: reset again mid-run
        cur_req = "R1";
        @(negedge clk); #1; rst_n = 0;
        step(); step();
        #1 rst_n = 1;
        step(); step();
        finish_run();
    end

endmodule